// File: doc/BRIEF.md
# External Trigger Conditioning Path

This block turns a raw external trigger pin into a clean level that a timer can use as a trigger or as a count clock. The pin first passes a two-flop synchronizer, then an optional polarity inversion. An edge-counting prescaler can divide its frequency by 1, 2, 4 or 8. A digital noise filter then accepts a new level only after a run of consecutive agreeing samples.

A single 4-bit filter code sets both the sampling rate and the run length N. The sampling rate is either the kernel clock or a divided rate of the dead-time clock. The dead-time clock reaches the block as a one-cycle tick, and a free-running divider turns that tick into sample enables at 1/2, 1/4, 1/8, 1/16 or 1/32 of its rate.

Top module: `etr_cond_top`

## Requirements
- R1: After reset, with the pin low and polarity 0, `trig_o` is 0.
- R2: With `pol_inv_i` = 0 the pin passes unchanged (active high, rising edge). With `pol_inv_i` = 1 it is inverted (active low, falling edge).
- R3: `psc_code_i` 0 passes the signal through. Codes 1, 2 and 3 divide the number of active edges by 2, 4 and 8, by toggling the divided signal every 2^(code-1) active edges.
- R4: With `filt_code_i` = 0 there is no filtering. A pin change shows on `trig_o` after the 3rd rising clock edge (two synchronizer stages plus one output register).
- R5: Filter codes 1, 2 and 3 sample on every kernel clock with N = 2, 4 and 8. The output changes after the (N+2)th clock edge following a pin change. A pulse covering N-1 samples is rejected.
- R6: Codes 4/5 sample every 2 dead-time ticks, 6/7 every 4, and 8/9 every 8, each pair with N = 6/8. Codes 10/11/12 sample every 16 ticks and 13/14/15 every 32, each group with N = 5/6/8. A pulse covering N-1 samples is rejected, and a held level is accepted after between (N-1)·d+3 and N·d+2 clock edges when the tick is always high.
- R7: Any sample that equals the current output level clears the consecutive-sample count, so an interrupted run is not accepted.
- R8: Under a dead-time-rate code, no sample is taken while `dts_tick_i` is low, so `trig_o` holds its level.
- R9: `trig_o` changes only in the cycle after a sample enable, and only towards the level that was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external trigger pin |
| dts_tick_i | input | 1 | One-cycle tick at the dead-time clock rate |
| pol_inv_i | input | 1 | 1 inverts the pin |
| psc_code_i | input | 2 | Prescaler code: 0 off, 1 /2, 2 /4, 3 /8 |
| filt_code_i | input | 4 | Filter rate and length code |
| trig_o | output | 1 | Conditioned trigger |

## Verification
The hardest case to reach is the exact boundary of the filter window at a divided sampling rate. The divider phase is hidden, so a pulse must be sized to cover exactly N-1 sample points whatever that phase is. The stimulus holds the tick high, which makes the sample period exactly d clocks. It then drives pulses that last an exact multiple of d. Such a pulse always spans N-1 samples, and a held level is then checked against a latency window that is valid for every divider phase. The interrupted-run case and the stalled-tick case are driven directly.

// File: rtl/etr_cond_pkg.sv
package etr_cond_pkg;
  localparam int FILT_CODE_W = 4;
  localparam int FILT_LEN_W  = 4;
  localparam int FILT_RATE_W = 3;

  // consecutive samples required per filter code
  function automatic logic [FILT_LEN_W-1:0] filt_len(input logic [FILT_CODE_W-1:0] c);
    case (c)
      4'd0:                      filt_len = 4'd1;
      4'd1:                      filt_len = 4'd2;
      4'd2:                      filt_len = 4'd4;
      4'd10, 4'd13:              filt_len = 4'd5;
      4'd4, 4'd6, 4'd8,
      4'd11, 4'd14:              filt_len = 4'd6;
      default:                   filt_len = 4'd8;
    endcase
  endfunction

  // log2 of dead-time tick divider, 0 = kernel clock
  function automatic logic [FILT_RATE_W-1:0] filt_rate(input logic [FILT_CODE_W-1:0] c);
    case (c)
      4'd4, 4'd5:                filt_rate = 3'd1;
      4'd6, 4'd7:                filt_rate = 3'd2;
      4'd8, 4'd9:                filt_rate = 3'd3;
      4'd10, 4'd11, 4'd12:       filt_rate = 3'd4;
      4'd13, 4'd14, 4'd15:       filt_rate = 3'd5;
      default:                   filt_rate = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/etr_cond_front.sv
module etr_cond_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_inv_i,
  output logic sig_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign sig_o = sync_q[SYNC_STAGES-1] ^ pol_inv_i;
endmodule

// File: rtl/etr_cond_prescaler.sv
module etr_cond_prescaler #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              sig_i,
  output logic              sig_o
);
  localparam int CNT_W = (1 << CODE_W) - 2;

  logic             prev_q, armed_q, tgl_q, rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit;

  // armed_q masks the edge a reset-time polarity flip would fake
  assign rise = armed_q & sig_i & ~prev_q;

  always_comb begin
    limit = '0;
    if (code_i != '0) limit = ((CNT_W+1)'(1) << (code_i - CODE_W'(1))) - (CNT_W+1)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      tgl_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= sig_i;
      armed_q <= 1'b1;
      if (code_i == '0) begin
        cnt_q <= '0;
      end else if (rise) begin
        if (cnt_q == limit[CNT_W-1:0]) begin
          cnt_q <= '0;
          tgl_q <= ~tgl_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign sig_o = (code_i == '0) ? sig_i : tgl_q;

  assert_toggle_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != '0 && !rise) |=> $stable(tgl_q));
endmodule

// File: rtl/etr_cond_sampler.sv
module etr_cond_sampler #(
  parameter int RATE_W = 3,
  parameter int DIV_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dts_tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              sample_en_o
);
  logic [DIV_W-1:0] div_q, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         div_q <= '0;
    else if (dts_tick_i) div_q <= div_q + DIV_W'(1);
  end

  assign mask        = (DIV_W'(1) << rate_i) - DIV_W'(1);
  assign sample_en_o = (rate_i == '0) ? 1'b1 : (dts_tick_i && ((div_q & mask) == mask));

  assert_no_tick_no_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i != '0 && !dts_tick_i) |-> !sample_en_o);
endmodule

// File: rtl/etr_cond_filter.sv
module etr_cond_filter #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_en_i,
  input  logic             sig_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sig_o
);
  logic             out_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (sample_en_i) begin
      if (sig_i == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(len_i - LEN_W'(1))) begin
        out_q <= sig_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sig_o = out_q;

  assert_change_on_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> $past(sample_en_i));
  assert_change_to_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> (out_q == $past(sig_i)));
  assert_restart_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && sig_i == out_q) |=> (cnt_q == '0));
endmodule

// File: rtl/etr_cond_top.sv
module etr_cond_top #(
  parameter int PSC_W  = 2,
  parameter int FILT_W = etr_cond_pkg::FILT_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              dts_tick_i,
  input  logic              pol_inv_i,
  input  logic [PSC_W-1:0]  psc_code_i,
  input  logic [FILT_W-1:0] filt_code_i,
  output logic              trig_o
);
  import etr_cond_pkg::*;

  logic                   pol_sig, psc_sig, samp_en;
  logic [FILT_LEN_W-1:0]  flen;
  logic [FILT_RATE_W-1:0] frate;

  assign flen  = filt_len(filt_code_i);
  assign frate = filt_rate(filt_code_i);

  etr_cond_front #(.SYNC_STAGES(2)) u_front (
    .clk_i, .rst_ni, .pin_i, .pol_inv_i, .sig_o(pol_sig)
  );

  etr_cond_prescaler #(.CODE_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .code_i(psc_code_i), .sig_i(pol_sig), .sig_o(psc_sig)
  );

  etr_cond_sampler #(.RATE_W(FILT_RATE_W), .DIV_W(5)) u_samp (
    .clk_i, .rst_ni, .dts_tick_i, .rate_i(frate), .sample_en_o(samp_en)
  );

  etr_cond_filter #(.LEN_W(FILT_LEN_W), .CNT_W(3)) u_filt (
    .clk_i, .rst_ni, .sample_en_i(samp_en), .sig_i(psc_sig), .len_i(flen), .sig_o(trig_o)
  );
endmodule

// File: tb/etr_cond_top_tb.sv
module etr_cond_top_tb_top;
  localparam int CLK_P = 10;
  // {code[11:8], N[7:4], log2 sample period[3:0]}
  localparam logic [11:0] FILT_TAB [16] = '{
    12'h010, 12'h120, 12'h240, 12'h380, 12'h461, 12'h581, 12'h662, 12'h782,
    12'h863, 12'h983, 12'hA54, 12'hB64, 12'hC84, 12'hD55, 12'hE65, 12'hF85};

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, dts = 1'b1, pol = 1'b0;
  logic [1:0] psc = '0;
  logic [3:0] filt = '0;
  logic trig;
  int n_run = 0, n_fail = 0;

  etr_cond_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dts_tick_i(dts), .pol_inv_i(pol),
    .psc_code_i(psc), .filt_code_i(filt), .trig_o(trig)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input logic target, input int limit, output int lat);
    lat = 0;
    while (trig !== target && lat < limit) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, lo, hi, seen, rises;
    string tag;
    @(negedge clk);

    // table walk: R4 / R5 / R6 per filter code
    for (int i = 0; i < 16; i++) begin
      int n, d;
      filt = FILT_TAB[i][11:8];
      n = int'(FILT_TAB[i][7:4]);
      d = 1 << FILT_TAB[i][3:0];
      tag = (filt == 0) ? "R4" : (filt <= 3) ? "R5" : "R6";
      psc = 0; pol = 0; dts = 1; pin = 0;
      do_reset();
      wait_cyc(4);
      chk(trig == 1'b0, "R1", int'(trig), 0);
      if (n > 1) begin
        pin = 1'b1;
        wait_cyc((n - 1) * d);
        pin = 1'b0;
        seen = 0;
        for (int k = 0; k < 2 * n * d + 8; k++) begin
          @(negedge clk);
          if (trig) seen = 1;
        end
        chk(seen == 0, tag, seen, 0);
      end
      lo = 3 + (n - 1) * d;
      hi = 2 + n * d;
      pin = 1'b1;
      measure(1'b1, hi + 10, lat);
      chk(lat >= lo && lat <= hi, tag, lat, hi);
      pin = 1'b0;
      measure(1'b0, hi + 10, lat);
      chk(lat >= lo && lat <= hi, tag, lat, hi);
    end

    // R2 polarity
    filt = 0; psc = 0; pol = 1; pin = 0;
    do_reset();
    wait_cyc(6);
    chk(trig == 1'b1, "R2", int'(trig), 1);
    pin = 1'b1;
    wait_cyc(4);
    chk(trig == 1'b0, "R2", int'(trig), 0);

    // R3 prescaler, both polarities
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        pol = p[0]; psc = c[1:0]; filt = 0; pin = p[0];
        do_reset();
        wait_cyc(10);
        rises = 0;
        for (int e = 0; e < 16; e++) begin
          for (int h = 0; h < 8; h++) begin
            logic prev;
            prev = trig;
            pin = (h < 4) ? ~p[0] : p[0];
            @(negedge clk);
            if (trig && !prev) rises++;
          end
        end
        for (int h = 0; h < 8; h++) begin
          logic prev;
          prev = trig;
          @(negedge clk);
          if (trig && !prev) rises++;
        end
        chk(rises == (16 >> c), "R3", rises, 16 >> c);
      end
    end

    // R7 interrupted run, N=4 at kernel rate
    filt = 4'd2; psc = 0; pol = 0; pin = 0;
    do_reset();
    wait_cyc(4);
    pin = 1'b1; wait_cyc(3);
    pin = 1'b0; wait_cyc(1);
    pin = 1'b1; wait_cyc(3);
    pin = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (trig) seen = 1;
    end
    chk(seen == 0, "R7", seen, 0);

    // R8 stalled tick holds output
    filt = 4'd4; dts = 0; pin = 0;
    do_reset();
    wait_cyc(4);
    pin = 1'b1;
    wait_cyc(60);
    chk(trig == 1'b0, "R8", int'(trig), 0);
    dts = 1'b1;
    wait_cyc(20);
    chk(trig == 1'b1, "R8", int'(trig), 1);

    // R1 reset clears a high output
    filt = 0; pin = 1'b1;
    wait_cyc(4);
    rst_n = 1'b0;
    #1;
    chk(trig == 1'b0, "R1", int'(trig), 0);
    pin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule